// File: doc/BRIEF.md
# Accumulator CPU with prefix-built operands

This block is a compact 32-bit processor core built around an accumulator. Its architectural state is a program counter, an A register (the accumulator), a B register and an operand register. Every instruction is a single byte: the high nibble is the opcode and the low nibble is a 4-bit immediate. Immediates wider than four bits come from prefix instructions placed just before the instruction that uses them. A positive prefix shifts the value collected so far left by one nibble. A negating prefix inverts it first and then shifts it, which is how negative values are formed.

The core talks to a single synchronous memory port. The port carries byte-addressed instruction fetches and 32-bit data words. A data word at word address w sits at byte address 4*w. Read data comes back on the cycle after the request. Each instruction runs through a fixed sequence: a fetch state, an execute state, and for loads one extra state that captures the returned word. A system call raises a request output and holds the core still until an acknowledge arrives. While it waits, A and B stay on output ports so outside logic can service the call.

Top module: `acc_core`

## Requirements
- R1: While reset is held and on the first cycle after it, regA and regB read 0, svcReq is low, and a fetch read is requested at byte address 0.
- R2: Opcode 0xE (positive prefix) sets the operand register to ((operand register OR nibble) << 4). Opcode 0xF (negating prefix) sets it to (~(operand register OR nibble)) << 4. Opcode 0x3 loads A with (operand register OR nibble) and opcode 0x4 loads B the same way, so any 32-bit constant can be built.
- R3: Every opcode other than 0xE and 0xF uses the operand value (operand register OR nibble) and then leaves the operand register at 0.
- R4: Direct accesses use the operand value as a word address (byte address = 4 × operand): 0x0 loads A, 0x1 loads B and 0x2 stores A. Every data write is word aligned.
- R5: Indexed accesses use B + operand value as the word address: 0x6 loads A, 0x7 loads B and 0x8 stores A.
- R6: Opcode 0x5 sets A to (address of the instruction + 1) + operand value.
- R7: Opcode 0x9 always branches to (address of the instruction + 1) + operand value. Negative offsets are supported.
- R8: Opcode 0xA takes the R7 branch only when A is 0, and opcode 0xB only when A bit 31 is set. Otherwise execution continues at the next byte.
- R9: Opcode 0xD with operand value 0 jumps to the address held in B, with 1 sets A = A + B, and with 2 sets A = A − B (modulo 2^32).
- R10: Opcode 0xD with operand value 3 raises svcReq and keeps it up until svcAck. During that wait there is no memory access and A and B do not change. On the cycle after the acknowledge, the core fetches the next byte.
- R11: Opcode 0xC, and opcode 0xD with any operand value above 3, change nothing except moving to the next byte and clearing the operand register.
- R12: A fetch takes one state and execution one more. Loads add one state. memRead and memWrite are never high together, and every store is followed at once by a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 32 | Byte address for a fetch or data access |
| memRead | output | 1 | Read request; data returns next cycle |
| memWrite | output | 1 | Write request for memWdata at memAddr |
| memWdata | output | 32 | Store data (the A register) |
| memRdata | input | 32 | Read data; a fetch uses bits 7:0 |
| svcReq | output | 1 | System-call request, held until acknowledged |
| svcAck | input | 1 | System-call acknowledge |
| regA | output | 32 | Current A register |
| regB | output | 32 | Current B register |

## Verification
In the execute cycle, the consuming instruction reads the combined operand and the operand register is cleared, both in the same cycle. This is provoked by placing a short instruction straight after a long prefixed one, for example a wide constant into A followed by a one-nibble constant into B. It is judged by B holding exactly its own nibble. A second overlap happens when a branch's relative target is formed in the same cycle that the program counter steps. Forward, backward and prefixed offsets check that the target is measured from the incremented address.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int NIB_W = 4;
  localparam int FN_BRB = 0;
  localparam int FN_ADD = 1;
  localparam int FN_SUB = 2;
  localparam int FN_SVC = 3;

  typedef enum logic [3:0] {
    OP_LDAM = 4'h0, OP_LDBM = 4'h1, OP_STAM = 4'h2, OP_LDAC = 4'h3,
    OP_LDBC = 4'h4, OP_LDAP = 4'h5, OP_LDAI = 4'h6, OP_LDBI = 4'h7,
    OP_STAI = 4'h8, OP_BR   = 4'h9, OP_BRZ  = 4'hA, OP_BRN  = 4'hB,
    OP_SPARE = 4'hC, OP_OPR = 4'hD, OP_PFIX = 4'hE, OP_NFIX = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_MEM, ST_SVC} state_e;
  typedef enum logic [1:0] {PC_KEEP, PC_INC, PC_REL, PC_BREG} pcSel_e;
  typedef enum logic [2:0] {A_KEEP, A_CONST, A_PCREL, A_ADD, A_SUB, A_MEM} aSel_e;
  typedef enum logic [1:0] {B_KEEP, B_CONST, B_MEM} bSel_e;
  typedef enum logic [1:0] {O_KEEP, O_PFIX, O_NFIX, O_CLEAR} oSel_e;
  typedef enum logic [1:0] {AD_PC, AD_DIRECT, AD_INDEX} adSel_e;

  typedef struct packed {
    pcSel_e pcSel;
    aSel_e  aSel;
    bSel_e  bSel;
    oSel_e  oSel;
    adSel_e adSel;
    logic   rd;
    logic   wr;
  } strobes_t;
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        instrOp,
  input  logic [DATA_W-1:0] oprnd,
  input  logic              aZero,
  input  logic              aNeg,
  input  logic              svcAck,
  output strobes_t          strb,
  output logic              svcReq
);
  state_e state, stateNext;
  logic   loadToB, loadToBNext;
  opcode_e op;

  assign op = opcode_e'(instrOp);
  assign svcReq = (state == ST_SVC);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FETCH;
      loadToB <= 1'b0;
    end else begin
      state   <= stateNext;
      loadToB <= loadToBNext;
    end
  end

  always_comb begin
    strb.pcSel  = PC_KEEP;
    strb.aSel   = A_KEEP;
    strb.bSel   = B_KEEP;
    strb.oSel   = O_KEEP;
    strb.adSel  = AD_PC;
    strb.rd     = 1'b0;
    strb.wr     = 1'b0;
    stateNext   = state;
    loadToBNext = loadToB;
    case (state)
      ST_FETCH: begin
        strb.rd   = 1'b1;
        stateNext = ST_EXEC;
      end
      ST_EXEC: begin
        strb.pcSel = PC_INC;
        strb.oSel  = O_CLEAR;
        stateNext  = ST_FETCH;
        case (op)
          OP_PFIX: strb.oSel = O_PFIX;
          OP_NFIX: strb.oSel = O_NFIX;
          OP_LDAM, OP_LDBM, OP_LDAI, OP_LDBI: begin
            strb.rd     = 1'b1;
            strb.adSel  = (op == OP_LDAI || op == OP_LDBI) ? AD_INDEX : AD_DIRECT;
            loadToBNext = (op == OP_LDBM || op == OP_LDBI);
            stateNext   = ST_MEM;
          end
          OP_STAM: begin strb.wr = 1'b1; strb.adSel = AD_DIRECT; end
          OP_STAI: begin strb.wr = 1'b1; strb.adSel = AD_INDEX; end
          OP_LDAC: strb.aSel = A_CONST;
          OP_LDBC: strb.bSel = B_CONST;
          OP_LDAP: strb.aSel = A_PCREL;
          OP_BR:   strb.pcSel = PC_REL;
          OP_BRZ:  if (aZero) strb.pcSel = PC_REL;
          OP_BRN:  if (aNeg) strb.pcSel = PC_REL;
          OP_OPR: begin
            if (oprnd == DATA_W'(FN_BRB))      strb.pcSel = PC_BREG;
            else if (oprnd == DATA_W'(FN_ADD)) strb.aSel = A_ADD;
            else if (oprnd == DATA_W'(FN_SUB)) strb.aSel = A_SUB;
            else if (oprnd == DATA_W'(FN_SVC)) stateNext = ST_SVC;
          end
          default: ;
        endcase
      end
      ST_MEM: begin
        if (loadToB) strb.bSel = B_MEM;
        else         strb.aSel = A_MEM;
        stateNext = ST_FETCH;
      end
      ST_SVC: if (svcAck) stateNext = ST_FETCH;
      default: stateNext = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [3:0]        instrOp,
  output logic [DATA_W-1:0] oprnd,
  output logic              aZero,
  output logic              aNeg,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB
);
  localparam int WORD_SHIFT = 2;

  logic [DATA_W-1:0] pc, oreg, pcInc;

  assign instrOp  = memRdata[2*NIB_W-1:NIB_W];
  assign oprnd    = oreg | DATA_W'(memRdata[NIB_W-1:0]);
  assign pcInc    = pc + DATA_W'(1);
  assign aZero    = (regA == '0);
  assign aNeg     = regA[DATA_W-1];
  assign memWdata = regA;

  always_comb begin
    case (strb.adSel)
      AD_DIRECT: memAddr = oprnd << WORD_SHIFT;
      AD_INDEX:  memAddr = (regB + oprnd) << WORD_SHIFT;
      default:   memAddr = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      oreg <= '0;
      regA <= '0;
      regB <= '0;
    end else begin
      case (strb.pcSel)
        PC_INC:  pc <= pcInc;
        PC_REL:  pc <= pcInc + oprnd;
        PC_BREG: pc <= regB;
        default: ;
      endcase
      case (strb.oSel)
        O_PFIX:  oreg <= oprnd << NIB_W;
        O_NFIX:  oreg <= (~oprnd) << NIB_W;
        O_CLEAR: oreg <= '0;
        default: ;
      endcase
      case (strb.aSel)
        A_CONST: regA <= oprnd;
        A_PCREL: regA <= pcInc + oprnd;
        A_ADD:   regA <= regA + regB;
        A_SUB:   regA <= regA - regB;
        A_MEM:   regA <= memRdata;
        default: ;
      endcase
      case (strb.bSel)
        B_CONST: regB <= oprnd;
        B_MEM:   regB <= memRdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] memAddr,
  output logic              memRead,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              svcReq,
  input  logic              svcAck,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB
);
  strobes_t          strb;
  logic [3:0]        instrOp;
  logic [DATA_W-1:0] oprnd;
  logic              aZero, aNeg;

  assign memRead  = strb.rd;
  assign memWrite = strb.wr;

  acc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .instrOp(instrOp), .oprnd(oprnd),
    .aZero(aZero), .aNeg(aNeg), .svcAck(svcAck),
    .strb(strb), .svcReq(svcReq)
  );

  acc_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .instrOp(instrOp),
    .oprnd(oprnd), .aZero(aZero), .aNeg(aNeg),
    .regA(regA), .regB(regB)
  );
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] memAddr,
  input logic              memRead,
  input logic              memWrite,
  input logic              svcReq,
  input logic              svcAck,
  input logic [DATA_W-1:0] regA,
  input logic [DATA_W-1:0] regB
);
  // R12: one port, one access kind per cycle
  p_no_rw_clash_r12: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

  // R12: a store is followed immediately by a fetch
  p_store_then_fetch_r12: assert property (@(posedge clk) disable iff (rst)
    memWrite |=> (memRead && !memWrite));

  // R4: data writes land on word boundaries
  p_store_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    memWrite |-> (memAddr[1:0] == 2'b00));

  // R10: request persists until acknowledged
  p_svc_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (svcReq && !svcAck) |=> svcReq);

  // R10: registers frozen while the call is outstanding
  p_svc_regs_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (svcReq && !svcAck) |=> ($stable(regA) && $stable(regB)));

  // R10: no memory traffic during the wait
  p_svc_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    svcReq |-> (!memRead && !memWrite));

  // R10: acknowledge releases the core into a fetch
  p_svc_resume_r10: assert property (@(posedge clk) disable iff (rst)
    (svcReq && svcAck) |=> (memRead && !svcReq));
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .memAddr(memAddr), .memRead(memRead),
  .memWrite(memWrite), .svcReq(svcReq), .svcAck(svcAck),
  .regA(regA), .regB(regB)
);

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;
  localparam logic [3:0] T_LDAM = 4'h0, T_LDBM = 4'h1, T_STAM = 4'h2, T_LDAC = 4'h3,
                         T_LDBC = 4'h4, T_LDAP = 4'h5, T_LDAI = 4'h6, T_LDBI = 4'h7,
                         T_STAI = 4'h8, T_BR = 4'h9, T_BRZ = 4'hA, T_BRN = 4'hB,
                         T_PFIX = 4'hE, T_NFIX = 4'hF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic svcAck = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata, regA, regB;
  logic memRead, memWrite, svcReq;

  logic [7:0] mem [0:1023];
  int nChecks = 0;
  int nFail = 0;
  int ptr = 0;

  always #2.5 clk = ~clk;

  acc_core u0 (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memRead(memRead),
    .memWrite(memWrite), .memWdata(memWdata), .memRdata(memRdata),
    .svcReq(svcReq), .svcAck(svcAck), .regA(regA), .regB(regB)
  );

  // memory model: one-cycle read latency, byte array, little-endian words
  always @(posedge clk) begin
    logic [9:0] a;
    a = memAddr[9:0];
    if (memRead) memRdata <= {mem[a + 10'd3], mem[a + 10'd2], mem[a + 10'd1], mem[a]};
    if (memWrite) begin
      mem[a]         = memWdata[7:0];
      mem[a + 10'd1] = memWdata[15:8];
      mem[a + 10'd2] = memWdata[23:16];
      mem[a + 10'd3] = memWdata[31:24];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdWord(input int w);
    logic [9:0] a;
    a = 10'(w * 4);
    return {mem[a + 10'd3], mem[a + 10'd2], mem[a + 10'd1], mem[a]};
  endfunction

  task automatic wrWord(input int w, input logic [31:0] v);
    logic [9:0] a;
    a = 10'(w * 4);
    mem[a] = v[7:0]; mem[a + 10'd1] = v[15:8];
    mem[a + 10'd2] = v[23:16]; mem[a + 10'd3] = v[31:24];
  endtask

  task automatic startProg();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    ptr = 0;
  endtask

  task automatic put(input logic [7:0] b);
    mem[ptr[9:0]] = b;
    ptr++;
  endtask

  // emits prefix chain + instruction carrying signed immediate v
  task automatic emit(input logic [3:0] op, input int v);
    logic [3:0] opc [0:15];
    logic [3:0] nib [0:15];
    int n = 0;
    int cur = v;
    logic [3:0] curOp = op;
    while (1) begin
      opc[n] = curOp;
      nib[n] = cur[3:0];
      n++;
      if (cur >= 0 && cur < 16) break;
      if (cur >= 16) begin curOp = T_PFIX; cur = cur >>> 4; end
      else begin curOp = T_NFIX; cur = (~cur) >>> 4; end
    end
    for (int i = n - 1; i >= 0; i--) put({opc[i], nib[i]});
  endtask

  task automatic runToSvc(input bit doReset, output int cycles);
    if (doReset) begin
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
    end
    cycles = 0;
    while (!svcReq && cycles < 3000) begin
      @(negedge clk);
      cycles++;
    end
    if (!svcReq) begin
      nChecks++; nFail++;
      $display("FAIL program hang actual=%0d expected=<3000", cycles);
    end
  endtask

  task automatic ackSvc();
    svcAck = 1'b1;
    @(negedge clk);
    svcAck = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    int cyc;
    logic signed [31:0] vals [0:7];
    vals = '{32'sd0, 32'sd1, -32'sd1, 32'sd7, -32'sd16, 32'sd300, 32'sh7fffffff, 32'sh80000000};
    @(negedge clk);

    // R2 / R3: immediate sweep, wide A constant followed by short B constant
    for (int k = -40; k <= 40; k++) begin
      int v;
      v = k * 37 + ((k < 0) ? -100000 : 4096);
      startProg();
      emit(T_LDAC, v);
      emit(T_LDBC, k & 15);
      put(8'hD3);
      runToSvc(1, cyc);
      check("R2 wide constant into A", regA, v);
      check("R3 short constant into B after prefix chain", regB, 32'(k & 15));
      ackSvc();
    end
    for (int i = 0; i < 8; i++) begin
      startProg();
      emit(T_LDBC, vals[i]);
      emit(T_LDAC, ~vals[i]);
      put(8'hD3);
      runToSvc(1, cyc);
      check("R2 extreme constant B", regB, vals[i]);
      check("R2 extreme constant A", regA, ~vals[i]);
      ackSvc();
    end

    // R4 / R5: direct and indexed memory sweep
    for (int w = 64; w < 80; w++) begin
      logic [31:0] p;
      p = 32'(w) * 32'h01010101 ^ 32'hA5000F00;
      startProg();
      wrWord(w, p);
      emit(T_LDAM, w);
      emit(T_LDBC, 50);
      emit(T_STAI, w - 50 + 20);
      emit(T_LDBI, w - 50);
      emit(T_LDAC, 5);
      emit(T_STAM, w + 40);
      put(8'hD3);
      runToSvc(1, cyc);
      check("R4 direct store word", rdWord(w + 40), 32'd5);
      check("R5 indexed store word", rdWord(w + 20), p);
      check("R5 indexed load into B", regB, p);
      check("R4 final A", regA, 32'd5);
      ackSvc();
    end
    // R4/R5: direct load B, indexed load A
    startProg();
    wrWord(90, 32'hCAFE0001);
    wrWord(95, 32'h0BADF00D);
    emit(T_LDBM, 90);
    emit(T_LDBC, 80);
    emit(T_LDAI, 15);
    put(8'hD3);
    runToSvc(1, cyc);
    check("R5 indexed load into A", regA, 32'h0BADF00D);
    ackSvc();
    startProg();
    wrWord(90, 32'hCAFE0001);
    emit(T_LDBM, 90);
    put(8'hD3);
    runToSvc(1, cyc);
    check("R4 direct load into B", regB, 32'hCAFE0001);
    ackSvc();

    // R6: PC-relative address, forward and backward offsets
    for (int off = -20; off <= 20; off++) begin
      int expA;
      startProg();
      put(8'h41);
      put(8'hC0);
      emit(T_LDAP, off);
      expA = ptr + off;
      put(8'hD3);
      runToSvc(1, cyc);
      check("R6 pc-relative address", regA, 32'(expA));
      ackSvc();
    end

    // R7 / R8: branch taken / not taken
    for (int i = 0; i < 8; i++) begin
      for (int c = 0; c < 3; c++) begin
        logic [3:0] cop;
        bit taken;
        cop = (c == 0) ? T_BR : (c == 1) ? T_BRZ : T_BRN;
        taken = (c == 0) ? 1'b1 : (c == 1) ? (vals[i] == 0) : vals[i][31];
        startProg();
        emit(T_LDAC, vals[i]);
        emit(T_LDBC, 0);
        put({cop, 4'd1});
        put({T_LDBC, 4'd7});
        put(8'hD3);
        runToSvc(1, cyc);
        check((c == 0) ? "R7 unconditional branch" : "R8 conditional branch",
              regB, taken ? 32'd0 : 32'd7);
        ackSvc();
      end
    end
    // R7: backward branch loop with negating prefix offset
    startProg();
    put(8'h33); put(8'h41);
    put(8'hD2); put(8'hA2); put(8'hF0); put(8'h9C);
    put(8'hD3);
    runToSvc(1, cyc);
    check("R7 backward loop A", regA, 32'd0);
    check("R7 backward loop B", regB, 32'd1);
    ackSvc();

    // R9: add/subtract sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        for (int s = 1; s <= 2; s++) begin
          startProg();
          emit(T_LDAC, vals[i]);
          emit(T_LDBC, vals[j]);
          put({4'hD, 4'(s)});
          put(8'hD3);
          runToSvc(1, cyc);
          check(s == 1 ? "R9 add" : "R9 subtract", regA,
                s == 1 ? 32'(vals[i] + vals[j]) : 32'(vals[i] - vals[j]));
          ackSvc();
        end
      end
    end
    // R9: branch through B
    startProg();
    put(8'h44); put(8'hD0); put(8'h39); put(8'hD3); put(8'h32); put(8'hD3);
    runToSvc(1, cyc);
    check("R9 branch to B", regA, 32'd2);
    ackSvc();

    // R11: spare opcode and out-of-range operate code
    startProg();
    put(8'hE3); put(8'hC7); put(8'h32); put(8'hD5); put(8'h41); put(8'hD3);
    runToSvc(1, cyc);
    check("R11 spare opcode clears operand", regA, 32'd2);
    check("R11 unused operate code no effect", regB, 32'd1);
    ackSvc();

    // R12: state count LDAC(2) + PFIX(2) + LDAM(3) + SVC(2) = 9
    startProg();
    wrWord(65, 32'h12345678);
    put(8'h31);
    emit(T_LDAM, 65);
    put(8'hD3);
    runToSvc(1, cyc);
    check("R12 cycles to system call", 32'(cyc), 32'd9);
    check("R12 load result", regA, 32'h12345678);
    ackSvc();

    // R10: system-call stall and resume
    startProg();
    put(8'h37); put(8'hD3); put(8'h38); put(8'hD3);
    runToSvc(1, cyc);
    check("R10 A visible at call", regA, 32'd7);
    repeat (5) @(negedge clk);
    check("R10 request held", {31'd0, svcReq}, 32'd1);
    check("R10 no read while waiting", {31'd0, memRead}, 32'd0);
    check("R10 A stable while waiting", regA, 32'd7);
    ackSvc();
    check("R10 fetch after acknowledge", {31'd0, memRead}, 32'd1);
    check("R10 resume address", memAddr, 32'd2);
    runToSvc(0, cyc);
    check("R10 continues after call", regA, 32'd8);
    ackSvc();

    // R1: reset state (A and B were nonzero before)
    startProg();
    put(8'h3F); put(8'h4E); put(8'hD3);
    runToSvc(1, cyc);
    rst = 1'b1;
    @(negedge clk);
    check("R1 svcReq low in reset", {31'd0, svcReq}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    check("R1 A cleared", regA, 32'd0);
    check("R1 B cleared", regB, 32'd0);
    check("R1 fetch request", {31'd0, memRead}, 32'd1);
    check("R1 fetch address zero", memAddr, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule